// File: doc/BRIEF.md
# Registered Command Buffer with Late Parity Check

This block is the clocked register stage that sits on a memory-module command and address bus. On every rising clock edge it captures a word of covered data bits and a few control bits that parity does not cover, and drives them out again. The parity bit for a word arrives one clock after the word. The block combines that bit with the word's own bits into a partial-parity output and raises an active-low error flag. The flag then stays low for two clocks, so slower logic can see it.

Two active-low chip-select inputs gate the data path for low-power operation. While both are high, the data outputs and the partial-parity output keep their values, and the word of that cycle is not checked. Two mode pins set the role. A standalone instance checks the whole word itself. In a cascade, two instances each take half of a wider bus: the lead instance passes its partial parity to the tail instance's parity input, and only the tail reports errors. Reset asserts asynchronously, wins over everything else, and is released through a two-stage synchroniser.

The error flag comes from a three-state machine. State CLEAR drives the flag high. A detected error in any state moves it to HOLD1. HOLD1 goes to HOLD2 when no new error is seen. HOLD2 goes back to CLEAR when no new error is seen. The flag is low in HOLD1 and HOLD2.

Top module: `cmdbuf_parity_reg`

## Requirements
- R1: While `rst_n` is low, `q_out`, `q_ctl` and `part_par` are 0 and `err_n` is 1. This takes effect as soon as `rst_n` falls, without a clock edge, whatever the chip-selects and data inputs do.
- R2: After `rst_n` rises, with `d_in` and `ctl_in` at zero and both chip-selects high, `q_out`, `q_ctl` and `part_par` stay 0 and `err_n` stays 1 on every cycle.
- R3: On a rising edge where at least one of `cs_a_n`/`cs_b_n` is low, `q_out` takes `d_in`. `q_ctl` takes `ctl_in` on every rising edge, whatever the chip-selects are.
- R4: On a rising edge where `cs_a_n` and `cs_b_n` are both high, `q_out` holds its value. The word of that edge is not parity-checked, and `part_par` does not change on the edge where that word's result would have been loaded.
- R5: The `par_bit` that belongs to a word is the value sampled on the rising edge that follows the edge that captured the word.
- R6: Standalone role (`mode_cascade`=0, `mode_upper` ignored): on the edge that samples a word's parity bit, `part_par` loads the XOR of the word's `DATA_W` bits and `par_bit`. Parity is odd, so a result of 0 is an error.
- R7: `ctl_in` bits take no part in any parity result.
- R8: After an error is detected on an edge, `err_n` is low for the next two clock cycles. An error detected while `err_n` is already low restarts the two-cycle window.
- R9: Lead role (`mode_cascade`=1, `mode_upper`=0): `part_par` behaves as in R6, but `err_n` stays at 1.
- R10: Tail role (`mode_cascade`=1, `mode_upper`=1): `par_bit` carries the lead's `part_par`. It is combined with this instance's word from two edges earlier, so `part_par` and `err_n` change on the third edge after the word. An error means the XOR over both halves and the controller's parity bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| mode_cascade | input | 1 | 0 = standalone, 1 = one half of a cascaded pair |
| mode_upper | input | 1 | In cascade: 0 = lead, 1 = tail |
| cs_a_n | input | 1 | Active-low chip-select, first rank |
| cs_b_n | input | 1 | Active-low chip-select, second rank |
| ctl_in | input | CTRL_W | Control bits that parity does not cover |
| d_in | input | DATA_W | Covered data bits |
| par_bit | input | 1 | Parity for the previous word, or the lead's partial parity |
| q_out | output | DATA_W | Registered data |
| q_ctl | output | CTRL_W | Registered control bits |
| part_par | output | 1 | Partial-parity result |
| err_n | output | 1 | Active-low stretched parity-error flag |

## Verification
On every cycle, the assertions check that reset forces the outputs to their idle values and that data is captured when a chip-select is active. They also check that both data and partial parity hold while both chip-selects are high, that a falling error flag stays low for at least one more cycle, and that a lead instance never raises an error. Only the bench scenarios can show the exact parity arithmetic and the one-cycle lag of the parity bit. The same holds for the restart of the stretch on back-to-back errors and for the three-edge latency of a cascaded pair. For these the bench runs a standalone instance and a wired lead/tail pair against a cycle-accurate model.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic [1:0] {
        ROLE_SOLO = 2'd0,
        ROLE_LEAD = 2'd1,
        ROLE_TAIL = 2'd2
    } role_e;

    typedef enum logic [1:0] {
        ERR_CLEAR = 2'd0,
        ERR_HOLD1 = 2'd1,
        ERR_HOLD2 = 2'd2
    } err_state_e;

    function automatic role_e decode_role(input logic cascade, input logic upper);
        if (!cascade) begin
            return ROLE_SOLO;
        end else if (upper) begin
            return ROLE_TAIL;
        end
        return ROLE_LEAD;
    endfunction

endpackage

// File: rtl/cmdbuf_rst_sync.sv
module cmdbuf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain_q;

    // Assert at once, release only after STAGES rising edges.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmdbuf_capture.sv
module cmdbuf_capture #(
    parameter int DATA_W = 14,
    parameter int CTRL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [DATA_W-1:0] d_in,
    input  logic [CTRL_W-1:0] ctl_in,
    output logic [DATA_W-1:0] q_out,
    output logic [CTRL_W-1:0] q_ctl
);
    // Control bits register every edge; data freezes while gated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_out <= '0;
            q_ctl <= '0;
        end else begin
            q_ctl <= ctl_in;
            if (!hold) begin
                q_out <= d_in;
            end
        end
    end
endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  role_e             role,
    input  logic              hold,
    input  logic [DATA_W-1:0] d_in,
    input  logic              par_bit,
    output logic              part_par,
    output logic              err_now
);
    localparam int TAIL_IDX = STAGES - 1;

    logic [STAGES-1:0] dp_q;
    logic [STAGES-1:0] ok_q;
    logic              word_xor;
    logic              sel_dp;
    logic              sel_ok;
    logic              sum;

    assign word_xor = ^d_in;

    // Word parity and its accepted flag travel down a short pipe so the
    // late parity bit (or the lead's result) meets the right word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
            ok_q <= '0;
        end else begin
            dp_q[0] <= word_xor;
            ok_q[0] <= !hold;
            for (int i = 1; i < STAGES; i++) begin
                dp_q[i] <= dp_q[i-1];
                ok_q[i] <= ok_q[i-1];
            end
        end
    end

    always_comb begin
        if (role == ROLE_TAIL) begin
            sel_dp = dp_q[TAIL_IDX];
            sel_ok = ok_q[TAIL_IDX];
        end else begin
            sel_dp = dp_q[0];
            sel_ok = ok_q[0];
        end
        sum     = sel_dp ^ par_bit;
        err_now = sel_ok && (role != ROLE_LEAD) && !sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_par <= 1'b0;
        end else if (sel_ok) begin
            part_par <= sum;
        end
    end
endmodule

// File: rtl/cmdbuf_err_fsm.sv
module cmdbuf_err_fsm
    import cmdbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_now,
    output logic err_n
);
    err_state_e state_q;
    err_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ERR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAR: state_d = err_now ? ERR_HOLD1 : ERR_CLEAR;
            ERR_HOLD1: state_d = err_now ? ERR_HOLD1 : ERR_HOLD2;
            ERR_HOLD2: state_d = err_now ? ERR_HOLD1 : ERR_CLEAR;
            default:   state_d = ERR_CLEAR;
        endcase
    end

    always_comb begin
        err_n = (state_q == ERR_CLEAR);
    end
endmodule

// File: rtl/cmdbuf_parity_reg.sv
module cmdbuf_parity_reg
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int CTRL_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int PAR_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cascade,
    input  logic              mode_upper,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [CTRL_W-1:0] ctl_in,
    input  logic [DATA_W-1:0] d_in,
    input  logic              par_bit,
    output logic [DATA_W-1:0] q_out,
    output logic [CTRL_W-1:0] q_ctl,
    output logic              part_par,
    output logic              err_n
);
    logic  rst_sync_n;
    logic  hold;
    logic  err_now;
    role_e role;

    assign hold = cs_a_n & cs_b_n;
    assign role = decode_role(mode_cascade, mode_upper);

    cmdbuf_rst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_rst (
        .clk    (clk),
        .arst_n (rst_n),
        .srst_n (rst_sync_n)
    );

    cmdbuf_capture #(
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .hold   (hold),
        .d_in   (d_in),
        .ctl_in (ctl_in),
        .q_out  (q_out),
        .q_ctl  (q_ctl)
    );

    cmdbuf_parity #(
        .DATA_W (DATA_W),
        .STAGES (PAR_STAGES)
    ) u_par (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .role     (role),
        .hold     (hold),
        .d_in     (d_in),
        .par_bit  (par_bit),
        .part_par (part_par),
        .err_now  (err_now)
    );

    cmdbuf_err_fsm u_err (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .err_now (err_now),
        .err_n   (err_n)
    );
endmodule

// File: rtl/cmdbuf_checker.sv
module cmdbuf_checker #(
    parameter int DATA_W = 14,
    parameter int CTRL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_sync_n,
    input logic              mode_cascade,
    input logic              mode_upper,
    input logic              cs_a_n,
    input logic              cs_b_n,
    input logic [DATA_W-1:0] d_in,
    input logic [CTRL_W-1:0] ctl_in,
    input logic [DATA_W-1:0] q_out,
    input logic [CTRL_W-1:0] q_ctl,
    input logic              part_par,
    input logic              err_n
);
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_forces: assert (q_out == '0 && q_ctl == '0 && !part_par && err_n)
                else $error("reset did not force idle outputs");
        end
    end

    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !(cs_a_n && cs_b_n) |=> q_out == $past(d_in));

    a_r3_ctl_always: assert property (@(posedge clk) disable iff (!rst_sync_n)
        $past(rst_sync_n) |-> q_ctl == $past(ctl_in));

    a_r4_hold_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (cs_a_n && cs_b_n) |=> $stable(q_out));

    a_r4_hold_par: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (cs_a_n && cs_b_n && !mode_cascade) |-> ##2 $stable(part_par));

    a_r8_stretch: assert property (@(posedge clk) disable iff (!rst_sync_n)
        $fell(err_n) |=> !err_n);

    a_r9_lead_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (mode_cascade && !mode_upper) |-> err_n);
endmodule

bind cmdbuf_parity_reg cmdbuf_checker #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n   (rst_sync_n),
    .mode_cascade (mode_cascade),
    .mode_upper   (mode_upper),
    .cs_a_n       (cs_a_n),
    .cs_b_n       (cs_b_n),
    .d_in         (d_in),
    .ctl_in       (ctl_in),
    .q_out        (q_out),
    .q_ctl        (q_ctl),
    .part_par     (part_par),
    .err_n        (err_n)
);

// File: tb/sim_cmdbuf_parity_reg.sv
module sim_cmdbuf_parity_reg;
    localparam int DW = 14;
    localparam int CW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          cs_a_n, cs_b_n;
    logic [CW-1:0] ctl;
    logic [DW-1:0] d_solo, d_lo, d_hi;
    logic          par_solo, par_casc;

    logic [DW-1:0] q0, q1, q2;
    logic [CW-1:0] c0, c1, c2;
    logic          pp0, pp1, pp2;
    logic          e0, e1, e2;

    cmdbuf_parity_reg u0 (
        .clk(clk), .rst_n(rst_n), .mode_cascade(1'b0), .mode_upper(1'b0),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .ctl_in(ctl), .d_in(d_solo),
        .par_bit(par_solo), .q_out(q0), .q_ctl(c0), .part_par(pp0), .err_n(e0));

    cmdbuf_parity_reg u_lead (
        .clk(clk), .rst_n(rst_n), .mode_cascade(1'b1), .mode_upper(1'b0),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .ctl_in(ctl), .d_in(d_lo),
        .par_bit(par_casc), .q_out(q1), .q_ctl(c1), .part_par(pp1), .err_n(e1));

    cmdbuf_parity_reg u_tail (
        .clk(clk), .rst_n(rst_n), .mode_cascade(1'b1), .mode_upper(1'b1),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .ctl_in(ctl), .d_in(d_hi),
        .par_bit(pp1), .q_out(q2), .q_ctl(c2), .part_par(pp2), .err_n(e2));

    typedef struct {
        logic [DW-1:0] q;
        logic [CW-1:0] ctl;
        logic          ppo;
        int            cnt;
        logic          dp1, dp2, ok1, ok2;
    } mdl_t;

    typedef struct {
        int            inst;
        logic [DW-1:0] q;
        logic [CW-1:0] ctl;
        logic          ppo;
        logic          err_n;
    } exp_t;

    exp_t sbq[$];
    mdl_t m0, m1, m2;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    logic [DW-1:0] prev_s, prev_l, prev_h;
    logic          prev_bad_s, prev_bad_c;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mdl_clear(output mdl_t m);
        m.q = '0; m.ctl = '0; m.ppo = 1'b0; m.cnt = 0;
        m.dp1 = 1'b0; m.dp2 = 1'b0; m.ok1 = 1'b0; m.ok2 = 1'b0;
    endtask

    // kind 0 standalone, 1 lead, 2 tail
    task automatic mdl_step(inout mdl_t m, input logic [DW-1:0] d, input logic [CW-1:0] c,
                            input logic hold, input logic par, input int kind);
        logic s;
        logic e;
        e = 1'b0;
        if (kind == 2) begin
            if (m.ok2) begin s = m.dp2 ^ par; m.ppo = s; e = !s; end
        end else if (m.ok1) begin
            s = m.dp1 ^ par; m.ppo = s; e = (kind == 0) && !s;
        end
        if (e) m.cnt = 2;
        else if (m.cnt > 0) m.cnt--;
        m.dp2 = m.dp1; m.ok2 = m.ok1;
        m.dp1 = ^d; m.ok1 = !hold;
        if (!hold) m.q = d;
        m.ctl = c;
    endtask

    task automatic push(input int inst, input mdl_t m);
        exp_t x;
        x.inst = inst; x.q = m.q; x.ctl = m.ctl; x.ppo = m.ppo; x.err_n = (m.cnt == 0);
        sbq.push_back(x);
    endtask

    // One bus cycle. bad_* marks this word's parity bit (sent next cycle) as wrong.
    task automatic drive(input logic ha, input logic hb, input logic bad_s, input logic bad_c);
        logic [DW-1:0] ns, nl, nh;
        logic [CW-1:0] nc;
        logic          ps, pc, lead_old, hold;
        @(negedge clk);
        ns = DW'($urandom); nl = DW'($urandom); nh = DW'($urandom); nc = CW'($urandom);
        ps = ~(^prev_s) ^ prev_bad_s;                 // R5: parity of previous word
        pc = ~(^prev_l ^ ^prev_h) ^ prev_bad_c;
        hold = ha & hb;
        cs_a_n = ha; cs_b_n = hb; ctl = nc;           // R7: ctl random, never in parity
        d_solo = ns; d_lo = nl; d_hi = nh;
        par_solo = ps; par_casc = pc;
        lead_old = m1.ppo;
        mdl_step(m0, ns, nc, hold, ps, 0);
        mdl_step(m2, nh, nc, hold, lead_old, 2);
        mdl_step(m1, nl, nc, hold, pc, 1);
        push(0, m0); push(1, m1); push(2, m2);
        prev_s = ns; prev_l = nl; prev_h = nh;
        prev_bad_s = bad_s; prev_bad_c = bad_c;
    endtask

    // Scoreboard monitor: compares after each edge, away from it.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sbq.size() > 0) begin
                exp_t x;
                logic [DW-1:0] aq;
                logic [CW-1:0] ac;
                logic          ap, ae;
                string         rp, re;
                x = sbq.pop_front();
                case (x.inst)
                    0: begin aq = q0; ac = c0; ap = pp0; ae = e0; rp = "R6"; re = "R8"; end
                    1: begin aq = q1; ac = c1; ap = pp1; ae = e1; rp = "R9"; re = "R9"; end
                    default: begin aq = q2; ac = c2; ap = pp2; ae = e2; rp = "R10"; re = "R10/R8"; end
                endcase
                chk("R3/R4", $sformatf("inst%0d q_out", x.inst), 32'(aq), 32'(x.q));
                chk("R3", $sformatf("inst%0d q_ctl", x.inst), 32'(ac), 32'(x.ctl));
                chk(rp, $sformatf("inst%0d part_par", x.inst), 32'(ap), 32'(x.ppo));
                chk(re, $sformatf("inst%0d err_n", x.inst), 32'(ae), 32'(x.err_n));
            end
        end
    end

    task automatic check_idle(input string req);
        chk(req, "u0 outs", {q0, c0, pp0, e0}, {{DW{1'b0}}, {CW{1'b0}}, 1'b0, 1'b1});
        chk(req, "lead outs", {q1, c1, pp1, e1}, {{DW{1'b0}}, {CW{1'b0}}, 1'b0, 1'b1});
        chk(req, "tail outs", {q2, c2, pp2, e2}, {{DW{1'b0}}, {CW{1'b0}}, 1'b0, 1'b1});
    endtask

    task automatic release_and_init();
        d_solo = '0; d_lo = '0; d_hi = '0; ctl = '0;
        cs_a_n = 1'b1; cs_b_n = 1'b1; par_solo = 1'b0; par_casc = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_idle("R2");
        end
        mdl_clear(m0); mdl_clear(m1); mdl_clear(m2);
        prev_s = '0; prev_l = '0; prev_h = '0; prev_bad_s = 1'b0; prev_bad_c = 1'b0;
    endtask

    task automatic drain();
        @(posedge clk);
        #6;
    endtask

    initial begin
        rst_n = 1'b0;
        cs_a_n = 1'b0; cs_b_n = 1'b0; ctl = '1; par_solo = 1'b1; par_casc = 1'b1;
        d_solo = '1; d_lo = '1; d_hi = '1;
        // R1: reset overrides active chip-selects and nonzero inputs
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_idle("R1");
        end
        release_and_init();

        for (int i = 0; i < 12; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        // single error (R6, R8, R10)
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        // back-to-back errors restart the stretch (R8)
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        // errors one clean word apart
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        // R4: gated words with bad parity are held and not checked
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        // one chip-select high alone still updates (R3)
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b0, 1'b0);
        // mixed random traffic
        for (int i = 0; i < 80; i++) begin
            drive(($urandom % 4) == 0, ($urandom % 3) == 0,
                  ($urandom % 8) == 0, ($urandom % 8) == 0);
        end
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);

        // R1: asynchronous reset in the middle of an error stretch
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drain();
        chk("R8", "u0 err_n before reset", 32'(e0), 32'(0));
        chk("R10", "tail err_n before reset", 32'(e2), 32'(0));
        #1;
        rst_n = 1'b0;
        #1;
        check_idle("R1");
        @(negedge clk);
        release_and_init();
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, ($urandom % 4) == 0, ($urandom % 4) == 0);
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule